// File: doc/BRIEF.md
# LIN Break Field Transmitter

This block produces the break field that opens a LIN frame on a UART transmit line. Software, or a neighbouring controller, sets a break length code and an interrupt-timing choice, then gives a one-cycle trigger. The block drives the line low for a whole number of bit times, from 13 to 20. It follows this with a single high stop bit. While it does this it raises a busy flag, and it issues one transmit interrupt pulse, either at the start or at the end of the sequence.

The bit time is set by a 12-bit baud divisor. One bit lasts `baud_div + 1` clock cycles. After the stop bit the transmitter stays in a post-break wait. It leaves that wait when the data path reports a write, or when another break trigger arrives. Clearing either of the two enables cancels the sequence immediately.

Top module: `lin_break_tx`

## Requirements
- R1: After reset, `txd` is 1, `brk_busy` is 0, `tx_irq` is 0 and `post_brk` is 0.
- R2: A `brk_trig` pulse is acted on only when `pwr_en` and `tx_en` are both 1. With either enable at 0 the trigger leaves `txd`, `brk_busy`, `tx_irq` and `post_brk` unchanged.
- R3: An accepted trigger drives `txd` low for exactly (13 + `brk_len`) bit times, where one bit time is `baud_div` + 1 clock cycles. Code 0 gives 13 bits and code 7 gives 20 bits. `brk_len` and `irq_at_end` are captured at the trigger.
- R4: `brk_busy` is 1 from the cycle after the accepted trigger until the stop bit has ended, which is (14 + `brk_len`) bit times in total. It then clears by itself.
- R5: With `irq_at_end` = 0, `tx_irq` pulses for exactly one cycle: the first cycle of the low period.
- R6: With `irq_at_end` = 1, `tx_irq` pulses for exactly one cycle: the first cycle after the stop bit, which is the cycle in which `brk_busy` reads 0.
- R7: A stop bit of one bit time with `txd` = 1 follows the low period, and `brk_busy` stays 1 during it.
- R8: After the stop bit, `post_brk` is 1 and `txd` is 1 until `data_wr` or an accepted trigger. `data_wr` clears `post_brk` in the following cycle. A trigger from this wait starts a new break.
- R9: A trigger that arrives while a break is in progress is ignored. The length and timing of the running break do not change.
- R10: Clearing `pwr_en` or `tx_en` cancels any break in progress. In the next cycle `txd` is 1 and `brk_busy` and `post_brk` are 0, and no interrupt is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_en | input | 1 | Block power enable |
| tx_en | input | 1 | Transmit enable |
| brk_trig | input | 1 | One-cycle break start request |
| brk_len | input | 3 | Break length code; low period is 13 + code bits |
| irq_at_end | input | 1 | 0: interrupt at break start, 1: after stop bit |
| baud_div | input | 12 | Bit time minus one, in clock cycles |
| data_wr | input | 1 | Pulse from the data path meaning new transmit data was written |
| txd | output | 1 | Serial transmit line |
| brk_busy | output | 1 | Break sequence in progress |
| tx_irq | output | 1 | One-cycle transmit interrupt |
| post_brk | output | 1 | Break finished, waiting for data or a new trigger |

## Verification
The hardest behaviour to reach from the ports is a second trigger in the middle of a running break. That trigger carries a different length code, so if it were taken it would both restart the count and change its limit. The bench injects it partway through the low period of a 13-bit break and then checks the measured low width. A cancel during a break that is set to interrupt at its end is also hard to reach. The bench drops `tx_en` in mid-break and then watches for many cycles to confirm that no late interrupt appears.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_STOP = 2'd2,
        ST_HOLD = 2'd3
    } lbk_state_e;
endpackage

// File: rtl/lbk_baud_gen.sv
module lbk_baud_gen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div);
        cnt_d = cnt_q + 1'b1;
        if (!run || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: a stopped generator always restarts from zero
    p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/lbk_bit_cnt.sv
module lbk_bit_cnt #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        last  = tick && (cnt_q == limit - 1'b1);
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: count never runs past the limit while counting
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> cnt_q < limit);
endmodule

// File: rtl/lin_break_tx.sv
module lin_break_tx #(
    parameter int DIV_W     = 12,
    parameter int LEN_W     = 3,
    parameter int BASE_BITS = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_en,
    input  logic             tx_en,
    input  logic             brk_trig,
    input  logic [LEN_W-1:0] brk_len,
    input  logic             irq_at_end,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             data_wr,
    output logic             txd,
    output logic             brk_busy,
    output logic             tx_irq,
    output logic             post_brk
);
    import lbk_pkg::*;

    localparam int MAX_BITS = BASE_BITS + (1 << LEN_W) - 1;
    localparam int CW       = $clog2(MAX_BITS + 1);

    typedef struct packed {
        lbk_state_e       st;
        logic [LEN_W-1:0] len;
        logic             at_end;
        logic             txd;
        logic             busy;
        logic             irq;
        logic             post;
    } lbk_regs_t;

    lbk_regs_t r_d, r_q;
    logic      en, run, tick, last, bclr;
    logic [CW-1:0] limit;

    assign en   = pwr_en && tx_en;
    assign run  = en && (r_q.st == ST_LOW || r_q.st == ST_STOP);
    assign bclr = !run || last;

    always_comb begin
        if (r_q.st == ST_LOW) limit = CW'(BASE_BITS) + CW'(r_q.len);
        else                  limit = CW'(1);
    end

    lbk_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(run), .div(baud_div), .tick(tick)
    );

    lbk_bit_cnt #(.CW(CW)) u_bits (
        .clk(clk), .rst_n(rst_n), .clr(bclr), .tick(tick),
        .limit(limit), .last(last)
    );

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;
        if (!en) begin
            r_d.st   = ST_IDLE;
            r_d.txd  = 1'b1;
            r_d.busy = 1'b0;
            r_d.post = 1'b0;
        end else begin
            case (r_q.st)
                ST_IDLE, ST_HOLD: begin
                    if (brk_trig) begin
                        r_d.st     = ST_LOW;
                        r_d.len    = brk_len;
                        r_d.at_end = irq_at_end;
                        r_d.txd    = 1'b0;
                        r_d.busy   = 1'b1;
                        r_d.irq    = !irq_at_end;
                        r_d.post   = 1'b0;
                    end else if (r_q.st == ST_HOLD && data_wr) begin
                        r_d.st   = ST_IDLE;
                        r_d.post = 1'b0;
                    end
                end
                ST_LOW: begin
                    if (last) begin
                        r_d.st  = ST_STOP;
                        r_d.txd = 1'b1;
                    end
                end
                ST_STOP: begin
                    if (last) begin
                        r_d.st   = ST_HOLD;
                        r_d.busy = 1'b0;
                        r_d.post = 1'b1;
                        r_d.irq  = r_q.at_end;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.len    <= '0;
            r_q.at_end <= 1'b0;
            r_q.txd    <= 1'b1;
            r_q.busy   <= 1'b0;
            r_q.irq    <= 1'b0;
            r_q.post   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign txd      = r_q.txd;
    assign brk_busy = r_q.busy;
    assign tx_irq   = r_q.irq;
    assign post_brk = r_q.post;

    // R2/R4: accepted trigger from rest starts a low, busy period
    p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!brk_busy && brk_trig && pwr_en && tx_en) |=> (brk_busy && !txd));
    // R3: the line is only low inside a busy period
    p_low_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !txd |-> brk_busy);
    // R5/R6: interrupt is a single-cycle pulse
    p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);
    // R10: dropping an enable ends everything next cycle
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_en && tx_en) |=> (txd && !brk_busy && !tx_irq && !post_brk));
    // R8: data write in the wait releases it
    p_wait_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (post_brk && data_wr && !brk_trig && pwr_en && tx_en) |=> !post_brk);
endmodule

// File: tb/sim_lin_break_tx.sv
module sim_lin_break_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_en = 1'b0, tx_en = 1'b0, brk_trig = 1'b0;
    logic [2:0]  brk_len = '0;
    logic        irq_at_end = 1'b0;
    logic [11:0] baud_div = '0;
    logic        data_wr = 1'b0;
    logic        txd, brk_busy, tx_irq, post_brk;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lin_break_tx u0 (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .tx_en(tx_en),
        .brk_trig(brk_trig), .brk_len(brk_len), .irq_at_end(irq_at_end),
        .baud_div(baud_div), .data_wr(data_wr), .txd(txd),
        .brk_busy(brk_busy), .tx_irq(tx_irq), .post_brk(post_brk)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one break and measures it; optional retrigger at index rt with length 7
    task automatic t_break(input int len, input bit at_end, input int div, input int rt);
        int bt, exp_low, exp_busy, low_n, busy_n, irq_n, irq_at, stop_txd, stop_busy;
        bt = div + 1;
        exp_low  = (13 + len) * bt;
        exp_busy = (14 + len) * bt;
        low_n = 0; busy_n = 0; irq_n = 0; irq_at = -1; stop_txd = 0; stop_busy = 0;
        @(negedge clk);
        baud_div = 12'(div); brk_len = 3'(len); irq_at_end = at_end; brk_trig = 1'b1;
        @(negedge clk);
        brk_trig = 1'b0;
        for (int i = 0; i < exp_busy + 6; i++) begin
            if (!txd) low_n++;
            if (brk_busy) busy_n++;
            if (tx_irq) begin irq_n++; irq_at = i; end
            if (i == exp_low) begin stop_txd = txd; stop_busy = brk_busy; end
            if (i == rt) begin brk_trig = 1'b1; brk_len = 3'd7; end
            else brk_trig = 1'b0;
            @(negedge clk);
        end
        brk_trig = 1'b0;
        chk(low_n == exp_low, (rt >= 0) ? "R9 low width" : "R3 low width", low_n, exp_low);
        chk(busy_n == exp_busy, "R4 busy width", busy_n, exp_busy);
        chk(stop_txd == 1, "R7 stop bit high", stop_txd, 1);
        chk(stop_busy == 1, "R7 busy in stop", stop_busy, 1);
        chk(irq_n == 1, at_end ? "R6 irq count" : "R5 irq count", irq_n, 1);
        chk(irq_at == (at_end ? exp_busy : 0), at_end ? "R6 irq cycle" : "R5 irq cycle",
            irq_at, at_end ? exp_busy : 0);
        chk(post_brk == 1 && txd == 1, "R8 wait after break", post_brk, 1);
    endtask

    task automatic t_reset();
        chk(txd == 1, "R1 txd", txd, 1);
        chk(brk_busy == 0, "R1 busy", brk_busy, 0);
        chk(tx_irq == 0, "R1 irq", tx_irq, 0);
        chk(post_brk == 0, "R1 post", post_brk, 0);
    endtask

    task automatic t_gated(input bit pw, input bit te);
        int bad;
        bad = 0;
        @(negedge clk);
        pwr_en = pw; tx_en = te; brk_trig = 1'b1;
        @(negedge clk);
        brk_trig = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (!txd || brk_busy || tx_irq || post_brk) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R2 gated trigger ignored", bad, 0);
        pwr_en = 1'b1; tx_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_hold();
        int bad;
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            if (!post_brk || !txd) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R8 wait persists", bad, 0);
        data_wr = 1'b1;
        @(negedge clk);
        data_wr = 1'b0;
        chk(post_brk == 0, "R8 data write clears wait", post_brk, 0);
    endtask

    task automatic t_abort();
        int irq_n;
        irq_n = 0;
        @(negedge clk);
        baud_div = 12'd2; brk_len = 3'd5; irq_at_end = 1'b1; brk_trig = 1'b1;
        @(negedge clk);
        brk_trig = 1'b0;
        repeat (9) @(negedge clk);
        chk(txd == 0 && brk_busy == 1, "R10 break running before abort", txd, 0);
        tx_en = 1'b0;
        @(negedge clk);
        chk(txd == 1, "R10 txd high after abort", txd, 1);
        chk(brk_busy == 0, "R10 busy cleared", brk_busy, 0);
        tx_en = 1'b1;
        for (int i = 0; i < 80; i++) begin
            if (tx_irq) irq_n++;
            @(negedge clk);
        end
        chk(irq_n == 0, "R10 no interrupt", irq_n, 0);
        chk(post_brk == 0 && txd == 1, "R10 no wait state", post_brk, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gated(1'b0, 1'b1);
        t_gated(1'b1, 1'b0);
        t_break(0, 1'b0, 1, -1);
        t_hold();
        t_break(7, 1'b1, 3, -1);
        t_break(3, 1'b0, 0, -1);     // started from the wait state (R8)
        t_hold();
        t_break(0, 1'b1, 1, 10);     // retrigger mid-break (R9)
        t_abort();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule